// File: doc/BRIEF.md
# Seven-Level Staircase Gate Pattern Generator

This block drives the ten switches of a single-phase seven-level inverter. The inverter is built from three equal-voltage half-bridge cells in series, followed by a polarity H-bridge. A 32-bit phase accumulator advances by a tuning word on every enabled clock. Three programmable threshold angles set where the staircase steps inside a quarter of the fundamental. The inverter can therefore produce 0, ±1, ±2 or ±3 times the cell voltage.

Within each half of the period, the phase is folded about the 90° point. The level is the number of active thresholds that the folded phase has reached, which gives quarter-wave and half-wave symmetry from only three numbers. The level sets which cells are inserted through complementary gate pairs. The half-cycle sets which diagonal of the bridge conducts.

The threshold values and the active count are captured at each period boundary, and continuously while the block is idle, so a waveform is never mixed from two settings. Three, five or seven output levels are chosen by activating one, two or three thresholds.

Top module: `stair7_gate_gen`

## Requirements
- R1: Cell k (k = 0..2) drives gate pair cell_gate[2k] (bypass switch) and cell_gate[2k+1] (insert switch). While enabled, cells with index below the level have the insert switch high and the bypass switch low. All other cells have the bypass switch high and the insert switch low.
- R2: The level is the count of active thresholds t that satisfy t ≤ min(p, 65536 − p). Here p is phase bits [30:15] read as an unsigned 16-bit fraction of 180°, and thresholds are 16-bit fractions of 180° packed at angle_in[16i+15:16i]. This applies both to the equal-phase set (i·180°/7) and to the step-pulse set for modulation index 0.8.
- R3: Bridge encoding, with bridge_gate bits 0..3 = P1..P4. When phase bit 31 = 0 and the level is nonzero, bits 0 and 1 are high. When phase bit 31 = 1 and the level is nonzero, bits 2 and 3 are high. At level 0 all four bits are low.
- R4: Threshold i takes part only when i < active_cnt. Inactive thresholds have no effect on the outputs.
- R5: The phase starts at 0 on the first enabled clock and grows by tune_word on each enabled clock, modulo 2^32. The gate outputs show the phase held one clock earlier.
- R6: Thresholds and active_cnt are copied into working registers only while disabled or on the clock where the phase wraps. A change made in the middle of a period appears from the following period onward.
- R7: Reset forces every gate low at once. On a clock where enable is low, every gate goes low, and the phase returns to 0.
- R8: No cell pair has both gates high. P1/P2 are never high together with P3/P4.
- R9: Over one period, the total number of gate-bit toggles is 8·z + 8, where z is the number of active thresholds that are nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run; low forces all gates off and clears the phase |
| tune_word | input | 32 | Phase increment per clock |
| angle_in | input | 48 | Three 16-bit threshold angles, fraction of 180° |
| active_cnt | input | 2 | Number of thresholds in use (1 to 3) |
| cell_gate | output | 6 | Cell switch gates, pair k at bits 2k (bypass) and 2k+1 (insert) |
| bridge_gate | output | 4 | Polarity bridge gates P1..P4 at bits 0..3 |

## Verification
Two things can fall in the same cycle: the phase wrap that reloads the working thresholds and the staircase evaluation at phase 0. A change to the thresholds in mid-period can therefore race against the boundary. The bench changes the threshold inputs about a third of the way into a period. It expects the old staircase on every sample up to the last phase before the wrap, and the new staircase from the sample that shows phase 0 onward. It also drops enable while the waveform is running and checks that the outputs go all-off and that the next run restarts from phase 0.

// File: rtl/stair7_pkg.sv
package stair7_pkg;

   // bridge gate codes, bit order P1..P4 at 0..3
   localparam logic [3:0] BRIDGE_OFF = 4'b0000;
   localparam logic [3:0] BRIDGE_POS = 4'b0011;
   localparam logic [3:0] BRIDGE_NEG = 4'b1100;

   // width that can hold a level count 0..n
   function automatic int level_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/s7_phase_acc.sv
module s7_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int TOP_W   = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [PHASE_W-1:0] tune_word,
   output logic [TOP_W-1:0]   phase_top,
   output logic               reload
);
   logic [PHASE_W-1:0] acc_q;
   logic [PHASE_W:0]   acc_sum;

   assign acc_sum   = {1'b0, acc_q} + {1'b0, tune_word};
   assign phase_top = acc_q[PHASE_W-1 -: TOP_W];
   // working registers follow the inputs while idle and at each wrap
   assign reload    = !enable || acc_sum[PHASE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (!enable)
         acc_q <= '0;
      else
         acc_q <= acc_sum[PHASE_W-1:0];
   end
endmodule

// File: rtl/s7_shadow_regs.sv
module s7_shadow_regs #(
   parameter int N_CELLS = 3,
   parameter int ANG_W   = 16,
   parameter int CNT_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reload,
   input  logic [N_CELLS*ANG_W-1:0] angle_in,
   input  logic [CNT_W-1:0]         cnt_in,
   output logic [N_CELLS*ANG_W-1:0] angle_q,
   output logic [CNT_W-1:0]         cnt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         angle_q <= '0;
         cnt_q   <= '0;
      end else if (reload) begin
         angle_q <= angle_in;
         cnt_q   <= cnt_in;
      end
   end
endmodule

// File: rtl/s7_level_calc.sv
module s7_level_calc #(
   parameter int N_CELLS = 3,
   parameter int ANG_W   = 16,
   parameter int LVL_W   = 2
) (
   input  logic [ANG_W:0]           phase_top,
   input  logic [N_CELLS*ANG_W-1:0] angle_q,
   input  logic [LVL_W-1:0]         cnt_q,
   output logic [LVL_W-1:0]         level,
   output logic                     neg_half
);
   localparam logic [ANG_W:0] HALF_SCALE = {1'b1, {ANG_W{1'b0}}};

   logic [ANG_W-1:0] in_half;
   logic [ANG_W:0]   folded;
   logic [N_CELLS-1:0] hit;

   assign neg_half = phase_top[ANG_W];
   assign in_half  = phase_top[ANG_W-1:0];
   // fold the in-half phase about 90 degrees
   assign folded   = in_half[ANG_W-1] ? (HALF_SCALE - {1'b0, in_half})
                                      : {1'b0, in_half};

   for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_thr
      localparam logic [LVL_W-1:0] IDX = LVL_W'(gi);
      logic [ANG_W-1:0] thr;
      assign thr     = angle_q[gi*ANG_W +: ANG_W];
      assign hit[gi] = (IDX < cnt_q) && ({1'b0, thr} <= folded);
   end

   always_comb begin
      level = '0;
      for (int i = 0; i < N_CELLS; i++)
         level = level + LVL_W'(hit[i]);
   end
endmodule

// File: rtl/s7_gate_map.sv
module s7_gate_map
   import stair7_pkg::*;
#(
   parameter int N_CELLS = 3,
   parameter int LVL_W   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   enable,
   input  logic [LVL_W-1:0]       level,
   input  logic                   neg_half,
   output logic [2*N_CELLS-1:0]   cell_gate,
   output logic [3:0]             bridge_gate
);
   logic [2*N_CELLS-1:0] cell_d;
   logic [3:0]           bridge_d;

   for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell
      localparam logic [LVL_W-1:0] IDX = LVL_W'(gi);
      logic inserted;
      assign inserted          = IDX < level;
      assign cell_d[2*gi]      = !inserted;
      assign cell_d[2*gi + 1]  = inserted;
   end

   always_comb begin
      if (level == '0)
         bridge_d = BRIDGE_OFF;
      else if (neg_half)
         bridge_d = BRIDGE_NEG;
      else
         bridge_d = BRIDGE_POS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cell_gate   <= '0;
         bridge_gate <= BRIDGE_OFF;
      end else if (!enable) begin
         cell_gate   <= '0;
         bridge_gate <= BRIDGE_OFF;
      end else begin
         cell_gate   <= cell_d;
         bridge_gate <= bridge_d;
      end
   end
endmodule

// File: rtl/stair7_gate_gen.sv
module stair7_gate_gen
   import stair7_pkg::*;
#(
   parameter int N_CELLS = 3,
   parameter int PHASE_W = 32,
   parameter int ANG_W   = 16,
   localparam int LVL_W  = level_width(N_CELLS),
   localparam int GATE_W = 2 * N_CELLS,
   localparam int ANGS_W = N_CELLS * ANG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [PHASE_W-1:0] tune_word,
   input  logic [ANGS_W-1:0]  angle_in,
   input  logic [LVL_W-1:0]   active_cnt,
   output logic [GATE_W-1:0]  cell_gate,
   output logic [3:0]         bridge_gate
);
   if (N_CELLS < 1) begin : g_bad_cells
      $error("N_CELLS must be at least 1");
   end
   if (ANG_W < 2 || ANG_W + 1 > PHASE_W) begin : g_bad_width
      $error("ANG_W must lie in 2..PHASE_W-1");
   end

   logic [ANG_W:0]      phase_top;
   logic                reload;
   logic [ANGS_W-1:0]   ang_work;
   logic [LVL_W-1:0]    cnt_work;
   logic [LVL_W-1:0]    stair_lvl;
   logic                neg_half;

   s7_phase_acc #(.PHASE_W(PHASE_W), .TOP_W(ANG_W + 1)) u_acc (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tune_word(tune_word),
      .phase_top(phase_top), .reload(reload));

   s7_shadow_regs #(.N_CELLS(N_CELLS), .ANG_W(ANG_W), .CNT_W(LVL_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .reload(reload), .angle_in(angle_in),
      .cnt_in(active_cnt), .angle_q(ang_work), .cnt_q(cnt_work));

   s7_level_calc #(.N_CELLS(N_CELLS), .ANG_W(ANG_W), .LVL_W(LVL_W)) u_level (
      .phase_top(phase_top), .angle_q(ang_work), .cnt_q(cnt_work),
      .level(stair_lvl), .neg_half(neg_half));

   s7_gate_map #(.N_CELLS(N_CELLS), .LVL_W(LVL_W)) u_map (
      .clk(clk), .rst_n(rst_n), .enable(enable), .level(stair_lvl),
      .neg_half(neg_half), .cell_gate(cell_gate), .bridge_gate(bridge_gate));
endmodule

// File: rtl/s7_gate_checker.sv
module s7_gate_checker #(
   parameter int N_CELLS = 3,
   parameter int LVL_W   = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 enable,
   input logic [2*N_CELLS-1:0] cell_gate,
   input logic [3:0]           bridge_gate,
   input logic [LVL_W-1:0]     stair_lvl
);
   logic [N_CELLS-1:0] lo_side, hi_side;
   logic               settled;

   for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_split
      assign lo_side[gi] = cell_gate[2*gi];
      assign hi_side[gi] = cell_gate[2*gi + 1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) settled <= 1'b0;
      else        settled <= 1'b1;
   end

   // R8: a cell pair never conducts on both switches
   p_pair_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_side & hi_side) == '0);

   // R8: the two bridge diagonals never overlap
   p_bridge_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !((bridge_gate[0] || bridge_gate[1]) && (bridge_gate[2] || bridge_gate[3])));

   // R3: each diagonal switches as a pair
   p_bridge_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bridge_gate[0] == bridge_gate[1]) && (bridge_gate[2] == bridge_gate[3]));

   // R7: a disabled clock leaves every gate low
   p_off_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (cell_gate == '0 && bridge_gate == 4'b0000));

   // R1: enabled output has one switch on per pair and inserts level cells
   p_cells_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && $past(enable)) |->
         ((lo_side ^ hi_side) == '1 && $countones(hi_side) == int'($past(stair_lvl))));

   // R3: zero level keeps the bridge open
   p_level0_bridge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && $past(enable) && $past(stair_lvl) == '0) |-> bridge_gate == 4'b0000);
endmodule

bind stair7_gate_gen s7_gate_checker #(.N_CELLS(N_CELLS), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .cell_gate(cell_gate),
   .bridge_gate(bridge_gate), .stair_lvl(stair_lvl));

// File: tb/stair7_gate_gen_bench.sv
module stair7_gate_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [31:0] tune_word = 32'h0040_0000;
   logic [47:0] angle_in = '0;
   logic [1:0]  active_cnt = 2'd0;
   logic [5:0]  cell_gate;
   logic [3:0]  bridge_gate;

   int checks = 0;
   int errors = 0;
   int excl_bad = 0;
   bit done = 0;

   // settings for the running period and for after a mid-period change
   int o1, o2, o3, ocnt, n1, n2, n3, ncnt;

   always #2.5 clk = ~clk;

   stair7_gate_gen u_stair7_gate_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tune_word(tune_word),
      .angle_in(angle_in), .active_cnt(active_cnt),
      .cell_gate(cell_gate), .bridge_gate(bridge_gate));

   // stimulus table: thresholds, active count, tuning word
   localparam int ROWS = 6;
   localparam int T_A1 [ROWS] = '{9362,  3433,  3433,  9362,  12000, 0};
   localparam int T_A2 [ROWS] = '{18725, 10773, 10773, 18725, 12000, 16384};
   localparam int T_A3 [ROWS] = '{28087, 20345, 20345, 28087, 25000, 32768};
   localparam int T_CNT[ROWS] = '{3,     3,     2,     1,     3,     3};
   localparam logic [31:0] T_FTW[ROWS] = '{32'h0040_0000, 32'h0040_0000, 32'h0040_0000,
                                          32'h0080_0000, 32'h0040_0000, 32'h0040_0000};

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected gates from phase and settings, {bridge, cells}
   function automatic logic [9:0] model(input logic [31:0] ph, input int b1, input int b2,
                                        input int b3, input int n);
      int p, m, lv;
      logic [5:0] c;
      logic [3:0] br;
      p = int'(ph[30:15]);
      m = (p > 32768) ? 65536 - p : p;
      lv = 0;
      if (n >= 1 && b1 <= m) lv++;
      if (n >= 2 && b2 <= m) lv++;
      if (n >= 3 && b3 <= m) lv++;
      for (int k = 0; k < 3; k++) begin
         c[2*k]     = !(k < lv);
         c[2*k + 1] = (k < lv);
      end
      br = 4'b0000;
      if (lv > 0) br = ph[31] ? 4'b1100 : 4'b0011;
      return {br, c};
   endfunction

   function automatic int nonzero_active(input int b1, input int b2, input int b3, input int n);
      int z = 0;
      if (n >= 1 && b1 != 0) z++;
      if (n >= 2 && b2 != 0) z++;
      if (n >= 3 && b3 != 0) z++;
      return z;
   endfunction

   // idle two clocks with the old settings, enable, then compare ncyc samples.
   // mism_pre counts mismatches in period 0, mism_post in later periods.
   task automatic run_seq(input logic [31:0] f, input int ncyc, input int swap_k,
                          output int mism_pre, output int mism_post, output int tog,
                          output logic [9:0] bad_a, output logic [9:0] bad_e);
      logic [9:0] prev, cur, exp;
      longint idx;
      mism_pre = 0; mism_post = 0; tog = 0; bad_a = '0; bad_e = '0; prev = '0;
      @(negedge clk);
      enable     = 1'b0;
      tune_word  = f;
      angle_in   = {16'(o3), 16'(o2), 16'(o1)};
      active_cnt = 2'(ocnt);
      @(negedge clk);
      @(negedge clk);
      enable = 1'b1;
      for (int k = 1; k <= ncyc; k++) begin
         @(posedge clk);
         #1;
         cur = {bridge_gate, cell_gate};
         idx = longint'(k - 1) * longint'(f);
         if (swap_k > 0 && (idx >> 32) >= 1)
            exp = model(idx[31:0], n1, n2, n3, ncnt);
         else
            exp = model(idx[31:0], o1, o2, o3, ocnt);
         if (cur != exp) begin
            if ((idx >> 32) >= 1) mism_post++; else mism_pre++;
            if (bad_a == '0 && bad_e == '0) begin bad_a = cur; bad_e = exp; end
         end
         if ((cur[0] & cur[1]) | (cur[2] & cur[3]) | (cur[4] & cur[5]) |
             ((cur[6] | cur[7]) & (cur[8] | cur[9])))
            excl_bad++;
         if (k >= 2) tog += $countones(cur ^ prev);
         prev = cur;
         if (swap_k > 0 && k == swap_k) begin
            @(negedge clk);
            angle_in   = {16'(n3), 16'(n2), 16'(n1)};
            active_cnt = 2'(ncnt);
         end
      end
   endtask

   initial begin
      int mp, mq, tg, per;
      logic [9:0] ba, be;

      // reset state
      repeat (3) @(negedge clk);
      check({bridge_gate, cell_gate} == 10'h000, "R7 reset gates low",
            32'({bridge_gate, cell_gate}), 32'h0);
      rst_n = 1'b1;

      // table walk: waveform and per-period toggle count
      for (int r = 0; r < ROWS; r++) begin
         o1 = T_A1[r]; o2 = T_A2[r]; o3 = T_A3[r]; ocnt = T_CNT[r];
         per = int'(64'h1_0000_0000 / {32'h0, T_FTW[r]});
         run_seq(T_FTW[r], per + 1, 0, mp, mq, tg, ba, be);
         check(mp + mq == 0, $sformatf("R1 R2 R3 R4 R5 staircase row %0d", r),
               32'(ba), 32'(be));
         check(tg == 8 * nonzero_active(o1, o2, o3, ocnt) + 8,
               $sformatf("R9 toggles per period row %0d", r),
               32'(tg), 32'(8 * nonzero_active(o1, o2, o3, ocnt) + 8));
      end

      // mid-period change: old set until the wrap, new set after it
      o1 = 9362; o2 = 18725; o3 = 28087; ocnt = 3;
      n1 = 3433; n2 = 10773; n3 = 20345; ncnt = 3;
      run_seq(32'h0040_0000, 1100, 300, mp, mq, tg, ba, be);
      check(mp == 0, "R6 old thresholds held to period end", 32'(ba), 32'(be));
      check(mq == 0, "R6 new thresholds from next period", 32'(ba), 32'(be));

      // disable while running
      @(negedge clk);
      enable = 1'b0;
      @(posedge clk);
      #1;
      check({bridge_gate, cell_gate} == 10'h000, "R7 disable forces gates low",
            32'({bridge_gate, cell_gate}), 32'h0);

      // restart from phase 0 with the new set
      o1 = n1; o2 = n2; o3 = n3; ocnt = ncnt;
      run_seq(32'h0040_0000, 600, 0, mp, mq, tg, ba, be);
      check(mp + mq == 0, "R5 restart at phase 0", 32'(ba), 32'(be));

      // asynchronous reset while enabled
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check({bridge_gate, cell_gate} == 10'h000, "R7 reset while running",
            32'({bridge_gate, cell_gate}), 32'h0);
      @(negedge clk);
      enable = 1'b0;
      rst_n  = 1'b1;

      check(excl_bad == 0, "R8 pair and bridge exclusivity", 32'(excl_bad), 32'h0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule